// File: doc/BRIEF.md
# Snoop Arbitration Controller

This block sits on the system side of a processor with a write-back cache. It lets an external bus master's access be checked against that cache. When the external master starts an access while it owns the bus, the controller passes the master's address strobe straight through as the processor's snoop strobe, in the same cycle. It also passes on whether the access should invalidate the line.

If the processor reports that the snoop hit a modified line, the controller aborts the master's access and gives the bus to the processor. To do this it asserts back-off to the master and drops HOLD in the same cycle. The processor then writes the dirty line back. After the write-back, the controller raises HOLD again and waits for hold-acknowledge. It then releases back-off so the master can retry its access at once. The retry is snooped in the same way as the first attempt. If no hit-modified report arrives within a fixed window, the access simply completes and back-off is never used.

A parameter sets when HOLD comes back. By default it waits for hit-modified to return high. In the early variant it rises the cycle after the processor starts its burst write-back.

Top module: `snoop_arbiter`

## Requirements
- R1: A synchronous active-high reset puts the controller in its idle state. After reset, `cpu_hold` = 1, `xm_backoff_n` = 1 and `snoop_strobe_n` = 1 while the master strobe is high.
- R2: In the idle state with `cpu_hold_ack` = 1, a low on `xm_strobe_n` drives `snoop_strobe_n` low in the same cycle. In that cycle `snoop_inv` equals `xm_write`. Whenever `snoop_strobe_n` is high, `snoop_inv` is 0.
- R3: A low `xm_strobe_n` is ignored when `cpu_hold_ack` = 0 or when the controller is not idle. `snoop_strobe_n` stays high, and no snoop starts.
- R4: A snoop opens a window of HIT_WINDOW sampled cycles. If `cpu_hitmod_n` is sampled low within that window, then in the next cycle `cpu_hold` goes to 0 and `xm_backoff_n` goes to 0 together.
- R5: If `cpu_hitmod_n` stays high for the whole window (4 cycles by default), the controller returns to idle. `cpu_hold` stays 1 and `xm_backoff_n` stays 1 throughout.
- R6: With EARLY_HOLD = 0, `cpu_hold` stays 0 while `cpu_hitmod_n` is low. It returns to 1 in the cycle after `cpu_hitmod_n` is sampled high.
- R7: With EARLY_HOLD = 1, `cpu_hold` returns to 1 in the cycle after `cpu_strobe_n` is sampled low during the write-back, even while `cpu_hitmod_n` is still low.
- R8: After the write-back, `xm_backoff_n` stays 0 until `cpu_hold_ack` = 1 and `cpu_hitmod_n` = 1 are sampled together. It rises to 1 in the next cycle.
- R9: The master's retry after back-off is released is snooped in the same way as the first access, as in R2.
- R10: `cpu_hitmod_n` going low while the controller is idle has no effect on `cpu_hold` or `xm_backoff_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xm_strobe_n | input | 1 | External master's address strobe, active low |
| xm_write | input | 1 | Master access is a write; requests invalidation on snoop |
| cpu_hitmod_n | input | 1 | Processor hit-modified report, active low |
| cpu_strobe_n | input | 1 | Processor's own address strobe, active low |
| cpu_hold_ack | input | 1 | Processor hold-acknowledge |
| snoop_strobe_n | output | 1 | Snoop strobe to the processor, active low |
| snoop_inv | output | 1 | Invalidate qualifier sent with the snoop strobe |
| cpu_hold | output | 1 | Bus hold request to the processor |
| xm_backoff_n | output | 1 | Back-off to the external master, active low |

## Verification
Some rules are checked by assertions on every cycle. The snoop strobe only appears while the master strobes and the processor holds the bus. HOLD and back-off change together one cycle after a hit. Back-off is only ever caused by a hit. Back-off is released only after hold-acknowledge. Under the default variant, HOLD stays low while hit-modified is low. Other behaviours can only be shown by the bench's scenarios: a snoop that misses and expires after its window, a hit ignored while idle, a retry that snoops again, reset in the middle of a write-back, and the early HOLD variant.

// File: rtl/snoop_arbiter.sv
module snoop_arbiter #(
  parameter int HIT_WINDOW = 4,
  parameter bit EARLY_HOLD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic xm_strobe_n,
  input  logic xm_write,
  input  logic cpu_hitmod_n,
  input  logic cpu_strobe_n,
  input  logic cpu_hold_ack,
  output logic snoop_strobe_n,
  output logic snoop_inv,
  output logic cpu_hold,
  output logic xm_backoff_n
);
  localparam int CW = $clog2(HIT_WINDOW + 1);

  typedef enum logic [1:0] {S_IDLE, S_SNOOP, S_WB, S_REGAIN} st_t;
  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic strobe_ok, wb_done;

  assign strobe_ok      = (st == S_IDLE) && cpu_hold_ack && !xm_strobe_n;
  assign snoop_strobe_n = !strobe_ok;
  assign snoop_inv      = strobe_ok && xm_write;
  assign cpu_hold       = (st != S_WB);
  assign xm_backoff_n   = (st == S_IDLE) || (st == S_SNOOP);
  assign wb_done        = EARLY_HOLD ? (cpu_hitmod_n || !cpu_strobe_n) : cpu_hitmod_n;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:   if (strobe_ok) st_nx = S_SNOOP;
      S_SNOOP:  if (!cpu_hitmod_n) st_nx = S_WB;
                else if (cnt == CW'(HIT_WINDOW - 1)) st_nx = S_IDLE;
      S_WB:     if (wb_done) st_nx = S_REGAIN;
      S_REGAIN: if (cpu_hold_ack && cpu_hitmod_n) st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st == S_SNOOP) ? cnt + 1'b1 : '0;
    end
  end

  p_snoop_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !snoop_strobe_n |-> (!xm_strobe_n && cpu_hold_ack && cpu_hold && xm_backoff_n));

  p_hit_abort_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_SNOOP && !cpu_hitmod_n) |=> (!cpu_hold && !xm_backoff_n));

  p_backoff_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(xm_backoff_n)) |-> !$past(cpu_hitmod_n));

  p_release_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(xm_backoff_n)) |-> ($past(cpu_hold_ack) && $past(cpu_hold)));

  generate
    if (!EARLY_HOLD) begin : g_late
      p_hold_low_r6: assert property (@(posedge clk) disable iff (rst)
        (!cpu_hold && !cpu_hitmod_n) |=> !cpu_hold);
    end
  endgenerate
endmodule

// File: tb/snoop_arbiter_bench.sv
module snoop_arbiter_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic xs, wr, hm, cs, ack;
  logic ss, sinv, hold, bo;
  logic e_xs, e_hm, e_cs, e_ack;
  logic e_ss, e_sinv, e_hold, e_bo;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  snoop_arbiter u_snoop_arbiter (
    .clk(clk), .rst(rst), .xm_strobe_n(xs), .xm_write(wr), .cpu_hitmod_n(hm),
    .cpu_strobe_n(cs), .cpu_hold_ack(ack), .snoop_strobe_n(ss), .snoop_inv(sinv),
    .cpu_hold(hold), .xm_backoff_n(bo));

  snoop_arbiter #(.HIT_WINDOW(4), .EARLY_HOLD(1'b1)) u_early (
    .clk(clk), .rst(rst), .xm_strobe_n(e_xs), .xm_write(1'b0), .cpu_hitmod_n(e_hm),
    .cpu_strobe_n(e_cs), .cpu_hold_ack(e_ack), .snoop_strobe_n(e_ss), .snoop_inv(e_sinv),
    .cpu_hold(e_hold), .xm_backoff_n(e_bo));

  // row: {xs, wr, hm, cs, ack, exp_ss, exp_inv, exp_hold, exp_bo}
  localparam int NV = 19;
  localparam logic [8:0] VEC [NV] = '{
    9'b10111_1011,  // R1 idle
    9'b01111_0111,  // R2 snoop strobe with invalidate
    9'b10111_1011,  // window open
    9'b10011_1011,  // hit sampled
    9'b10011_1000,  // R4 hold and back-off together
    9'b00000_1000,  // R3 strobe ignored, R6 hold low
    9'b10010_1000,  // R6
    9'b10110_1000,  // hit-modified released
    9'b10110_1010,  // R6 hold back, R8 back-off kept
    9'b10111_1010,  // R8 ack sampled
    9'b00111_0011,  // R8 released, R9 retry snooped
    9'b10111_1011,
    9'b10111_1011,
    9'b10111_1011,  // window expires
    9'b10111_1011,  // R5 no back-off
    9'b10011_1011,  // R10 hit while idle
    9'b10111_1011,  // R10 no effect
    9'b00110_1011,  // R3 strobe without ack
    9'b10011_1011   // R3 no snoop started
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xs = 1'b1; wr = 1'b0; hm = 1'b1; cs = 1'b1; ack = 1'b1;
    e_xs = 1'b1; e_hm = 1'b1; e_cs = 1'b1; e_ack = 1'b1;
    step; step; step;
    rst = 1'b0;
    #1;
    chk("R1 hold", hold, 1'b1);
    chk("R1 backoff", bo, 1'b1);
    chk("R1 strobe", ss, 1'b1);

    for (int i = 0; i < NV; i++) begin
      step;
      {xs, wr, hm, cs, ack} = VEC[i][8:4];
      #1;
      chk($sformatf("R2/R3 strobe row %0d", i), ss, VEC[i][3]);
      chk($sformatf("R2 inv row %0d", i), sinv, VEC[i][2]);
      chk($sformatf("R4-R6 hold row %0d", i), hold, VEC[i][1]);
      chk($sformatf("R4/R8 backoff row %0d", i), bo, VEC[i][0]);
    end

    // R1: reset in the middle of a write-back
    step; xs = 1'b0; hm = 1'b1; ack = 1'b1;
    step; xs = 1'b1; hm = 1'b0;
    step; #1;
    chk("R4 hold before reset", hold, 1'b0);
    rst = 1'b1;
    step; rst = 1'b0; hm = 1'b1; #1;
    chk("R1 hold after reset", hold, 1'b1);
    chk("R1 backoff after reset", bo, 1'b1);

    // R7: early hold variant
    step; e_xs = 1'b0;
    step; e_xs = 1'b1; e_hm = 1'b0;
    step; e_ack = 1'b0; #1;
    chk("R4 early hold drop", e_hold, 1'b0);
    chk("R4 early backoff", e_bo, 1'b0);
    step; e_cs = 1'b0;
    step; e_cs = 1'b1; #1;
    chk("R7 hold back during write-back", e_hold, 1'b1);
    chk("R8 backoff still held", e_bo, 1'b0);
    step; e_ack = 1'b1; #1;
    chk("R8 backoff held while hitmod low", e_bo, 1'b0);
    step; e_hm = 1'b1;
    step; #1;
    chk("R8 early backoff released", e_bo, 1'b1);
    chk("R2 early strobe idle", e_ss, 1'b1);
    chk("R2 early inv idle", e_sinv, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule